// File: doc/BRIEF.md
# Periodic Interrupt Rate Divider

This block turns a slow time-base strobe (nominally 32.768 kHz, presented as a one-cycle enable in the system clock domain) into periodic tick events for a real-time-clock style status register. A free-running prescaler counts base strobes. Whenever the new prescaler value lands on a multiple of the selected period, the block emits a one-cycle flag-set pulse. A second pulse, meant for the summary interrupt flag, fires alongside it when the periodic interrupt enable is on.

The period comes from a 4-bit rate code. Code zero switches ticks off. A nonzero code gives a power-of-two period, except that the two lowest codes are moved to slower rates. A 3-bit divider-control field and a set-mode bit decide whether the prescaler advances, stays frozen, or is held cleared. The block reports the chain condition on two status outputs. The status register, the interrupt line, the square-wave pin and the time-of-day counters sit outside this block.

Top module: `periodic_tick_divider`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears the prescaler to 0 and keeps `pf_set` and `irqf_set` low.
- R2: With `rate_code` equal to 0, `pf_set` never pulses.
- R3: For `rate_code` from 3 to 15, `pf_set` pulses once per 2^(rate_code-1) advances of the prescaler.
- R4: Code 1 behaves as code 8 and gives a period of 128 advances. Code 2 behaves as code 9 and gives a period of 256 advances.
- R5: The prescaler advances by one, wrapping modulo 32768, on each clock with `base_tick` high while running. A tick happens on the advance whose new count is a multiple of the period. A rate change therefore takes effect at the next boundary of the new period, and the prescaler is not cleared.
- R6: The chain runs only when `div_ctrl` is 0, 1 or 2 and `set_mode` is low. When it is neither running nor held, the prescaler keeps its value and no tick occurs.
- R7: When `div_ctrl[2:1]` is 2'b11 (values 6 and 7), the chain is held: the prescaler is cleared to 0 and no tick occurs, whatever the state of `set_mode`.
- R8: `pf_set` is a one-cycle pulse registered one clock after the advancing edge. `irqf_set` pulses in the same cycle only if `pie` was high at that edge, and never without `pf_set`.
- R9: `chain_running` and `chain_held` combinationally reflect the run (R6) and hold (R7) conditions of the present inputs, and are never both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| base_tick | input | 1 | One-cycle strobe at the 32.768 kHz time-base rate |
| rate_code | input | 4 | Periodic rate select; 0 disables ticks |
| div_ctrl | input | 3 | Divider-control field; values 6 and 7 hold the chain in reset |
| set_mode | input | 1 | Set-mode bit; high freezes the chain |
| pie | input | 1 | Periodic interrupt enable |
| pf_set | output | 1 | One-cycle pulse that sets the periodic flag |
| irqf_set | output | 1 | One-cycle pulse that sets the summary interrupt flag |
| chain_running | output | 1 | Prescaler is advancing on base strobes |
| chain_held | output | 1 | Prescaler is held cleared |
| prescale_count | output | 15 | Present prescaler value |

## Verification
The hardest cases to reach are the far end of the rate range and the moment the prescaler wraps. The slowest code only ticks a second time when the count rolls from 32767 back to 0. The bench gets there by driving the base strobe on every clock, so a full 32768-step revolution fits in the run. Each code in the sweep starts from a cleared prescaler, which it reaches by pulsing the hold pattern. A mid-period rate change, a sparse strobe pattern, and freeze and hold episodes are then laid over a cycle-by-cycle arithmetic model of the prescaler.

// File: rtl/ptd_pkg.sv
package ptd_pkg;

    localparam int PRESCALE_W_DEF = 15;
    localparam int RATE_W_DEF     = 4;
    localparam int DIV_W_DEF      = 3;
    localparam int RUN_MAX_DEF    = 2;
    localparam int REMAP_ADD_DEF  = 7;

    typedef enum logic [1:0] {
        CHAIN_FROZEN = 2'd0,
        CHAIN_RUN    = 2'd1,
        CHAIN_HELD   = 2'd2
    } chain_state_e;

endpackage

// File: rtl/ptd_rate_decode.sv
module ptd_rate_decode
    import ptd_pkg::*;
#(
    parameter int RATE_W     = RATE_W_DEF,
    parameter int PRESCALE_W = PRESCALE_W_DEF,
    parameter bit REMAP_LOW  = 1'b1,
    parameter int REMAP_ADD  = REMAP_ADD_DEF
) (
    input  logic [RATE_W-1:0]     rate_code,
    output logic                  tick_en,
    output logic [PRESCALE_W-1:0] grid_mask
);
    localparam int SHIFT_W = $clog2(PRESCALE_W + 1);

    logic [SHIFT_W-1:0] shift;

    generate
        if (REMAP_LOW) begin : g_remap
            always_comb begin
                int eff;
                eff = int'(rate_code);
                if (eff == 1 || eff == 2) begin
                    eff = eff + REMAP_ADD;
                end
                shift = (eff == 0) ? '0 : SHIFT_W'(eff - 1);
            end
        end else begin : g_plain
            always_comb begin
                int eff;
                eff   = int'(rate_code);
                shift = (eff == 0) ? '0 : SHIFT_W'(eff - 1);
            end
        end
    endgenerate

    always_comb begin
        tick_en   = (rate_code != '0);
        grid_mask = ~({PRESCALE_W{1'b1}} << shift);
    end

    // R3: a period mask is always a contiguous run of low ones
    always_comb begin
        if (tick_en == 1'b1) begin
            p_mask_contig_r3: assert ($onehot({1'b0, grid_mask} + 1'b1))
                else $error("grid mask not a power-of-two minus one");
        end
    end

endmodule

// File: rtl/ptd_chain_ctrl.sv
module ptd_chain_ctrl
    import ptd_pkg::*;
#(
    parameter int DIV_W   = DIV_W_DEF,
    parameter int RUN_MAX = RUN_MAX_DEF
) (
    input  logic [DIV_W-1:0] div_ctrl,
    input  logic             set_mode,
    output chain_state_e     chain_state,
    output logic             run,
    output logic             held
);
    logic hold_pat;
    logic run_pat;

    always_comb begin
        hold_pat = &div_ctrl[DIV_W-1:DIV_W-2];
        run_pat  = (int'(div_ctrl) <= RUN_MAX) && !set_mode;
        if (hold_pat) begin
            chain_state = CHAIN_HELD;
        end else if (run_pat) begin
            chain_state = CHAIN_RUN;
        end else begin
            chain_state = CHAIN_FROZEN;
        end
        run  = (chain_state == CHAIN_RUN);
        held = (chain_state == CHAIN_HELD);
    end

endmodule

// File: rtl/ptd_prescaler.sv
module ptd_prescaler
    import ptd_pkg::*;
#(
    parameter int PRESCALE_W = PRESCALE_W_DEF
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  base_tick,
    input  logic                  run,
    input  logic                  held,
    input  logic                  tick_en,
    input  logic [PRESCALE_W-1:0] grid_mask,
    output logic [PRESCALE_W-1:0] count,
    output logic                  tick_next
);
    typedef struct packed {
        logic [PRESCALE_W-1:0] count;
    } pre_state_t;

    pre_state_t state_d, state_q;
    logic [PRESCALE_W-1:0] step;

    always_comb begin
        state_d   = state_q;
        step      = state_q.count + 1'b1;
        tick_next = 1'b0;
        if (held) begin
            state_d.count = '0;
        end else if (run && base_tick) begin
            state_d.count = step;
            tick_next     = tick_en && ((step & grid_mask) == '0);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign count = state_q.count;

    // R7: a held chain leaves the prescaler at zero
    p_held_clear_r7: assert property (@(posedge clk) disable iff (rst)
        held |=> (count == '0))
        else $error("prescaler not cleared while held");

    // R6: a frozen chain keeps its count
    p_frozen_keep_r6: assert property (@(posedge clk) disable iff (rst)
        (!run && !held) |=> $stable(count))
        else $error("prescaler moved while frozen");

endmodule

// File: rtl/periodic_tick_divider.sv
module periodic_tick_divider
    import ptd_pkg::*;
#(
    parameter int PRESCALE_W = PRESCALE_W_DEF,
    parameter int RATE_W     = RATE_W_DEF,
    parameter int DIV_W      = DIV_W_DEF
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  base_tick,
    input  logic [RATE_W-1:0]     rate_code,
    input  logic [DIV_W-1:0]      div_ctrl,
    input  logic                  set_mode,
    input  logic                  pie,
    output logic                  pf_set,
    output logic                  irqf_set,
    output logic                  chain_running,
    output logic                  chain_held,
    output logic [PRESCALE_W-1:0] prescale_count
);
    typedef struct packed {
        logic pf;
        logic irqf;
    } flag_state_t;

    flag_state_t flag_d, flag_q;

    logic                  tick_en;
    logic [PRESCALE_W-1:0] grid_mask;
    logic                  run;
    logic                  held;
    logic                  tick_next;
    chain_state_e          chain_state;

    ptd_rate_decode #(
        .RATE_W     (RATE_W),
        .PRESCALE_W (PRESCALE_W),
        .REMAP_LOW  (1'b1),
        .REMAP_ADD  (REMAP_ADD_DEF)
    ) u_rate (
        .rate_code (rate_code),
        .tick_en   (tick_en),
        .grid_mask (grid_mask)
    );

    ptd_chain_ctrl #(
        .DIV_W   (DIV_W),
        .RUN_MAX (RUN_MAX_DEF)
    ) u_chain (
        .div_ctrl    (div_ctrl),
        .set_mode    (set_mode),
        .chain_state (chain_state),
        .run         (run),
        .held        (held)
    );

    ptd_prescaler #(
        .PRESCALE_W (PRESCALE_W)
    ) u_pre (
        .clk       (clk),
        .rst       (rst),
        .base_tick (base_tick),
        .run       (run),
        .held      (held),
        .tick_en   (tick_en),
        .grid_mask (grid_mask),
        .count     (prescale_count),
        .tick_next (tick_next)
    );

    always_comb begin
        flag_d      = '0;
        flag_d.pf   = tick_next;
        flag_d.irqf = tick_next && pie;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q <= '0;
        end else begin
            flag_q <= flag_d;
        end
    end

    assign pf_set        = flag_q.pf;
    assign irqf_set      = flag_q.irqf;
    assign chain_running = run;
    assign chain_held    = held;

    // R2: code zero yields no tick on the following cycle
    p_code0_quiet_r2: assert property (@(posedge clk) disable iff (rst)
        (rate_code == '0) |=> !pf_set)
        else $error("tick with rate code zero");

    // R5: every tick lands on the period grid selected at its edge
    p_on_grid_r5: assert property (@(posedge clk) disable iff (rst)
        pf_set |-> ((prescale_count & $past(grid_mask)) == '0))
        else $error("tick off the period grid");

    // R8: flag pulse lasts one cycle
    p_pf_single_r8: assert property (@(posedge clk) disable iff (rst)
        pf_set |=> !pf_set)
        else $error("periodic flag pulse longer than one cycle");

    // R8: summary pulse only together with the periodic pulse
    p_irq_with_pf_r8: assert property (@(posedge clk) disable iff (rst)
        irqf_set |-> pf_set)
        else $error("summary pulse without periodic pulse");

    // R9: running and held are exclusive
    p_status_excl_r9: assert property (@(posedge clk) disable iff (rst)
        !(chain_running && chain_held))
        else $error("chain both running and held");

endmodule

// File: tb/periodic_tick_divider_bench.sv
module periodic_tick_divider_bench;

    localparam int W    = 15;
    localparam int WRAP = 32768;

    logic        clk = 1'b0;
    logic        rst;
    logic        base_tick;
    logic [3:0]  rate_code;
    logic [2:0]  div_ctrl;
    logic        set_mode;
    logic        pie;
    logic        pf_set;
    logic        irqf_set;
    logic        chain_running;
    logic        chain_held;
    logic [W-1:0] prescale_count;

    int checks = 0;
    int errors = 0;
    bit mon_on = 1'b0;

    int m_cnt = 0;
    bit m_pf  = 1'b0;
    bit m_irq = 1'b0;
    string m_tag = "R1";

    int seen_pf = 0;
    int seen_irq = 0;
    int first_pf_cnt = -1;

    always #10 clk = ~clk;

    periodic_tick_divider u_periodic_tick_divider (
        .clk            (clk),
        .rst            (rst),
        .base_tick      (base_tick),
        .rate_code      (rate_code),
        .div_ctrl       (div_ctrl),
        .set_mode       (set_mode),
        .pie            (pie),
        .pf_set         (pf_set),
        .irqf_set       (irqf_set),
        .chain_running  (chain_running),
        .chain_held     (chain_held),
        .prescale_count (prescale_count)
    );

    function automatic int period_of(input int code);
        int eff;
        eff = code;
        if (code == 1) eff = 8;
        if (code == 2) eff = 9;
        return 1 << (eff - 1);
    endfunction

    function automatic bit exp_run(input int d, input bit s);
        return (d <= 2) && !s;
    endfunction

    function automatic bit exp_held(input int d);
        return d >= 6;
    endfunction

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // reference model, updated at the same edges as the design
    always @(posedge clk) begin
        int nxt;
        bit tk;
        tk = 1'b0;
        if (rst) begin
            m_cnt = 0;
            m_tag = "R1";
        end else if (exp_held(int'(div_ctrl))) begin
            m_cnt = 0;
            m_tag = "R7";
        end else if (exp_run(int'(div_ctrl), set_mode)) begin
            m_tag = "R5";
            if (base_tick) begin
                nxt   = (m_cnt + 1) % WRAP;
                m_cnt = nxt;
                tk    = (rate_code != 0) && ((nxt % period_of(int'(rate_code))) == 0);
            end
        end else begin
            m_tag = "R6";
        end
        m_pf  = tk;
        m_irq = tk && pie;
    end

    always @(negedge clk) begin
        if (mon_on) begin
            chk(m_tag, "prescale_count", int'(prescale_count), m_cnt);
            chk((rate_code == 0) ? "R2" : ((rate_code <= 2) ? "R4" : "R3"),
                "pf_set", int'(pf_set), int'(m_pf));
            chk("R8", "irqf_set", int'(irqf_set), int'(m_irq));
            chk("R9", "chain_running", int'(chain_running),
                int'(exp_run(int'(div_ctrl), set_mode) && !exp_held(int'(div_ctrl))));
            chk("R9", "chain_held", int'(chain_held), int'(exp_held(int'(div_ctrl))));
            if (pf_set) begin
                seen_pf++;
                if (first_pf_cnt < 0) first_pf_cnt = int'(prescale_count);
            end
            if (irqf_set) seen_irq++;
        end
    end

    task automatic cyc(input int n, input int gap);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #2;
            base_tick = ((i % gap) == 0);
        end
        @(posedge clk);
        #2;
        base_tick = 1'b0;
        @(posedge clk);
        #2;
    endtask

    task automatic clear_seen();
        seen_pf      = 0;
        seen_irq     = 0;
        first_pf_cnt = -1;
    endtask

    task automatic hold_then_run(input int code);
        @(posedge clk);
        #2;
        base_tick = 1'b0;
        div_ctrl  = 3'd6;
        @(posedge clk);
        #2;
        div_ctrl  = 3'd2;
        rate_code = 4'(code);
        clear_seen();
    endtask

    initial begin
        int saved;
        rst       = 1'b1;
        base_tick = 1'b1;
        rate_code = 4'd3;
        div_ctrl  = 3'd2;
        set_mode  = 1'b0;
        pie       = 1'b1;
        repeat (3) @(posedge clk);
        #2;
        @(negedge clk);
        chk("R1", "count in reset", int'(prescale_count), 0);
        chk("R1", "pf in reset", int'(pf_set), 0);
        chk("R1", "irqf in reset", int'(irqf_set), 0);
        @(posedge clk);
        #2;
        rst       = 1'b0;
        base_tick = 1'b0;
        mon_on    = 1'b1;

        // sweep every rate code from a cleared prescaler
        for (int c = 0; c < 16; c++) begin
            int n;
            int exp_t;
            hold_then_run(c);
            pie   = c[0];
            n     = (c == 0) ? 256 : 2 * period_of(c);
            exp_t = (c == 0) ? 0 : 2;
            cyc(n, 1);
            chk((c == 0) ? "R2" : ((c <= 2) ? "R4" : "R3"), $sformatf("ticks code %0d", c),
                seen_pf, exp_t);
            chk("R8", $sformatf("irq ticks code %0d", c), seen_irq, pie ? exp_t : 0);
            if (c != 0) chk("R5", $sformatf("first tick count code %0d", c),
                            first_pf_cnt, period_of(c) % WRAP);
        end

        // rate change mid-period: code 5 for 10 advances, then code 3
        hold_then_run(5);
        pie = 1'b1;
        cyc(10, 1);
        chk("R5", "no tick before change", seen_pf, 0);
        rate_code = 4'd3;
        clear_seen();
        cyc(8, 1);
        chk("R5", "first tick after rate change", first_pf_cnt, 12);
        chk("R5", "count kept across rate change", int'(prescale_count), 18);

        // sparse base strobe
        hold_then_run(4);
        cyc(48, 3);
        chk("R3", "ticks with sparse strobe", seen_pf, 2);
        chk("R5", "count with sparse strobe", int'(prescale_count), 16);

        // freeze by set mode, then by divider values 3..5
        hold_then_run(3);
        cyc(6, 1);
        saved = int'(prescale_count);
        set_mode = 1'b1;
        clear_seen();
        cyc(40, 1);
        chk("R6", "frozen by set mode count", int'(prescale_count), saved);
        chk("R6", "no ticks under set mode", seen_pf, 0);
        set_mode = 1'b0;
        for (int d = 3; d <= 5; d++) begin
            div_ctrl = 3'(d);
            clear_seen();
            cyc(20, 1);
            chk("R6", $sformatf("frozen div %0d count", d), int'(prescale_count), saved);
            chk("R6", $sformatf("no ticks div %0d", d), seen_pf, 0);
        end

        // hold with pattern 7 and set mode
        div_ctrl = 3'd7;
        set_mode = 1'b1;
        clear_seen();
        cyc(20, 1);
        chk("R7", "held count", int'(prescale_count), 0);
        chk("R7", "held status", int'(chain_held), 1);
        chk("R7", "no ticks while held", seen_pf, 0);
        set_mode = 1'b0;
        div_ctrl = 3'd1;
        rate_code = 4'd3;
        clear_seen();
        cyc(4, 1);
        chk("R7", "first tick after release", first_pf_cnt, 4);

        // synchronous reset in mid-run
        cyc(5, 1);
        @(posedge clk);
        #2;
        rst = 1'b1;
        base_tick = 1'b1;
        @(posedge clk);
        #2;
        @(negedge clk);
        chk("R1", "count after mid reset", int'(prescale_count), 0);
        chk("R1", "pf after mid reset", int'(pf_set), 0);
        @(posedge clk);
        #2;
        rst = 1'b0;
        base_tick = 1'b0;
        cyc(4, 1);

        mon_on = 1'b0;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule